// File: doc/BRIEF.md
# Three-Master Backplane Bus Arbiter

This block sits on the board of the default bus owner and decides which of up to three masters may drive a shared asynchronous 8-bit backplane. The local master owns the bus unless another master has taken it. Two further masters ask for the bus on active-low request pins and receive active-low grant pins. Request 0 ranks above request 1.

Ownership moves only between transfers. Before it takes a grant away, the arbiter waits until the active-low address strobe of the current owner has gone inactive. It then leaves one clock with no grant at all and gives the bus to the winner. Requests and the strobe are brought into the arbiter's clock domain through flop synchronisers. A master that holds the bus keeps it for as long as its request stays low, even if the other request is also asserted.

Top module: `bus_arbiter3`

## Requirements
- R1: While reset is asserted, and on leaving reset, `host_gnt` is 1 and `gnt_n` is 2'b11. This holds even if a remote master owned the bus before reset.
- R2: At most one grant is active at any time. The grants are `host_gnt` high, `gnt_n[0]` low and `gnt_n[1]` low.
- R3: With the strobe inactive, a request held low ahead of a rising edge gives these outputs. Through the second edge the host keeps the bus. After the third edge no grant is active. After the fourth edge the requester's grant line is low.
- R4: If both requests are pending when the bus becomes free, requester 0 (bit 0 of `req_n`/`gnt_n`) is granted first.
- R5: A granted remote master keeps its grant while its request stays low, whatever the other request does.
- R6: No grant is withdrawn while the synchronised address strobe shows a transfer in progress. A grant is removed only if `astb_n` was high SYNC_STAGES+1 edges earlier.
- R7: Every handover passes through exactly one clock cycle with no grant active. A new grant rises only after such a cycle.
- R8: When a remote master releases its request, the bus goes to the other remote master if that one's request is pending, and to the host otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 2 | Active-low bus requests from the two remote masters; bit 0 has priority |
| astb_n | input | 1 | Active-low address strobe of the current owner's transfer |
| gnt_n | output | 2 | Active-low bus grants; bit k answers req_n[k] |
| host_gnt | output | 1 | Active-high grant to the default (local) master |

## Verification
The checker checks four things on every cycle. At most one grant is active. Every new grant is preceded by a single empty cycle. A grant never falls while the delayed strobe history shows a transfer. A remote grant is never removed while the delayed request history shows the request still held. The bench scenarios cover the rest. These are the exact four-edge latency from an idle bus, the priority choice when both requests meet at a decision point, the hold-off of a requester while the host or another master is mid-transfer, the release path to the other requester or back to the host, and the reset state, including a reset that arrives while a remote master owns the bus.

// File: rtl/bus_arbiter3.sv
module bus_arbiter3 #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_n,
  input  logic       astb_n,
  output logic [1:0] gnt_n,
  output logic       host_gnt
);

  typedef enum logic [1:0] {ST_HOST, ST_GAP, ST_P0, ST_P1} own_t;

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] rq0_sh, rq1_sh, stb_sh;
  own_t         own_q, own_d;
  logic         rq0, rq1, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq0_sh <= '0;
      rq1_sh <= '0;
      stb_sh <= '0;
    end else begin
      rq0_sh <= {rq0_sh[MSB-1:0], ~req_n[0]};
      rq1_sh <= {rq1_sh[MSB-1:0], ~req_n[1]};
      stb_sh <= {stb_sh[MSB-1:0], ~astb_n};
    end
  end

  assign rq0  = rq0_sh[MSB];
  assign rq1  = rq1_sh[MSB];
  assign busy = stb_sh[MSB];

  always_comb begin
    own_d = own_q;
    case (own_q)
      ST_HOST: if ((rq0 || rq1) && !busy) own_d = ST_GAP;
      ST_P0:   if (!rq0 && !busy)         own_d = ST_GAP;
      ST_P1:   if (!rq1 && !busy)         own_d = ST_GAP;
      default: own_d = rq0 ? ST_P0 : (rq1 ? ST_P1 : ST_HOST);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= ST_HOST;
    else        own_q <= own_d;
  end

  assign host_gnt = (own_q == ST_HOST);
  assign gnt_n    = ~{own_q == ST_P1, own_q == ST_P0};

endmodule

// File: rtl/bus_arbiter3_chk.sv
module bus_arbiter3_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_n,
  input logic       astb_n,
  input logic [1:0] gnt_n,
  input logic       host_gnt
);

  logic [SYNC_STAGES:0] stb_h, r0_h, r1_h;
  logic none_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_h <= '1;
      r0_h  <= '1;
      r1_h  <= '1;
    end else begin
      stb_h <= {stb_h[SYNC_STAGES-1:0], astb_n};
      r0_h  <= {r0_h[SYNC_STAGES-1:0], req_n[0]};
      r1_h  <= {r1_h[SYNC_STAGES-1:0], req_n[1]};
    end
  end

  assign none_act = !host_gnt && (gnt_n == 2'b11);

  p_single_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({host_gnt, ~gnt_n}) <= 1);

  p_gap_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    none_act |=> !none_act);

  p_grant_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_gnt) || $fell(gnt_n[0]) || $fell(gnt_n[1])) |-> $past(none_act));

  p_host_drop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_gnt) |-> (stb_h[SYNC_STAGES] && !(r0_h[SYNC_STAGES] && r1_h[SYNC_STAGES])));

  p_p0_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_n[0]) |-> (stb_h[SYNC_STAGES] && r0_h[SYNC_STAGES]));

  p_p1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_n[1]) |-> (stb_h[SYNC_STAGES] && r1_h[SYNC_STAGES]));

endmodule

bind bus_arbiter3 bus_arbiter3_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .astb_n(astb_n),
  .gnt_n(gnt_n), .host_gnt(host_gnt)
);

// File: tb/bus_arbiter3_bench.sv
module bus_arbiter3_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req_n = 2'b11;
  logic       astb_n = 1'b1;
  logic [1:0] gnt_n;
  logic       host_gnt;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bus_arbiter3 u_bus_arbiter3 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .astb_n(astb_n),
    .gnt_n(gnt_n), .host_gnt(host_gnt)
  );

  // {req_n[1:0], astb_n, expected host_gnt, expected gnt_n[1:0]}
  localparam int NV = 15;
  localparam logic [5:0] VEC [NV] = '{
    6'b11_1_1_11,  // idle, host owns
    6'b10_1_0_10,  // R3 req0 granted
    6'b00_1_0_10,  // R5 req1 arrives, req0 keeps bus
    6'b01_1_0_01,  // R8 req0 drops, req1 pending -> req1
    6'b00_1_0_01,  // R5 req0 returns, no preemption
    6'b11_1_1_11,  // R8 all drop -> host
    6'b00_1_0_10,  // R4 both at decision, req0 wins
    6'b00_0_0_10,  // req0 transfer running
    6'b01_0_0_10,  // R6 req0 drops mid-transfer, hold
    6'b01_1_0_01,  // R6 strobe released -> req1
    6'b11_1_1_11,  // back to host
    6'b11_0_1_11,  // host transfer running
    6'b01_0_1_11,  // R6 req1 waits for host strobe
    6'b01_1_0_01,  // strobe released -> req1
    6'b11_1_1_11   // R8 release -> host
  };

  task automatic check(input string tag, input logic exp_h, input logic [1:0] exp_g);
    n_chk++;
    if (host_gnt !== exp_h || gnt_n !== exp_g) begin
      n_err++;
      $display("FAIL %s: host_gnt=%b gnt_n=%b expected host_gnt=%b gnt_n=%b",
               tag, host_gnt, gnt_n, exp_h, exp_g);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b1, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b1, 2'b11);

    for (int i = 0; i < NV; i++) begin
      req_n  = VEC[i][5:4];
      astb_n = VEC[i][3];
      repeat (6) @(negedge clk);
      check($sformatf("R2/R4/R5/R6/R8 vector %0d", i), VEC[i][2], VEC[i][1:0]);
    end

    // R3 / R7 exact latency from idle bus
    req_n = 2'b01;
    repeat (2) @(negedge clk);
    check("R3 host still owns after edge 2", 1'b1, 2'b11);
    @(negedge clk);
    check("R7 empty cycle after edge 3", 1'b0, 2'b11);
    @(negedge clk);
    check("R3 req1 granted after edge 4", 1'b0, 2'b01);

    // R8 release latency back to host, with R7 gap
    req_n = 2'b11;
    repeat (3) @(negedge clk);
    check("R7 empty cycle on release", 1'b0, 2'b11);
    @(negedge clk);
    check("R8 host regains bus", 1'b1, 2'b11);

    // R6 exact: strobe released, grant falls SYNC_STAGES+1 edges later
    req_n = 2'b10;
    astb_n = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 host held while strobe low", 1'b1, 2'b11);
    astb_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 host still held after edge 2", 1'b1, 2'b11);
    @(negedge clk);
    check("R6 R7 gap after edge 3", 1'b0, 2'b11);
    @(negedge clk);
    check("R6 req0 granted after edge 4", 1'b0, 2'b10);

    // R1 reset while a remote master owns the bus
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset overrides remote owner", 1'b1, 2'b11);
    req_n = 2'b11;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 host after reset release", 1'b1, 2'b11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule